// File: doc/BRIEF.md
# Generic Short Packet Capture Queue

This block sits behind a camera-link receiver's packet header decoder. Each decoded short packet header arrives on one cycle with a valid strobe, carrying its data type, virtual channel and 16-bit payload. The block keeps only the headers whose data type falls in the generic short packet class. It packs each kept header into one 24-bit entry and queues it in an internal first-in first-out store. Every other header is dropped without trace.

Software drains the queue through a read strobe. Each strobe returns the oldest entry as a 32-bit word and removes that entry. A strobe on an empty queue returns zero and leaves the queue unharmed. A small control state machine has two states, FLUSH and RUN. Reset and the idle state is FLUSH. The edge FLUSH->RUN is taken when the core is enabled and no soft reset is requested. The edge RUN->FLUSH is taken as soon as either condition stops holding. While the controller is in FLUSH, the queue, the read word and the overflow flag are held at zero. The queue occupancy is tracked by a second state machine with the states EMPTY, PARTIAL and FULL. It moves EMPTY->PARTIAL on a first push, PARTIAL->FULL when the last slot fills, FULL->PARTIAL on a pop, PARTIAL->EMPTY when the last entry leaves, and back to EMPTY on a flush. The empty and full flags come straight from this state, ready to be mapped into a status register. A qualifying header that finds the queue full is lost, and a sticky overflow flag records the loss.

Top module: `gsp_capture_top`

## Requirements
- R1: A header is queued only when it is valid and its 6-bit data type lies in 0x08..0x0F inclusive. Headers with any other data type leave the queue and all flags unchanged.
- R2: A read word carries the payload in bits 23:8, the virtual channel in bits 7:6 and the data type in bits 5:0. Bits 31:24 are always zero.
- R3: The queue holds at most 31 entries. `fifo_full` is high exactly when 31 entries are held.
- R4: A qualifying header that arrives while the queue is full is discarded, and the queued entries stay unchanged. `ovf_flag` rises on the cycle after the discard and stays high until a flush or reset.
- R5: A cycle with `rd_stb` high pops the oldest entry. The popped value appears on `rd_data` from the next cycle and holds until the next strobe. Entries come out in arrival order.
- R6: A strobe while the queue is empty loads zero into `rd_data`. The queue stays empty, and a following push and read behave normally.
- R7: While `rst_n` is low, the queue is empty, `fifo_full` and `ovf_flag` are low, and `rd_data` is zero.
- R8: A cycle with `soft_rst` high moves the controller to FLUSH. From the second cycle after that one, the queue is empty, `ovf_flag` is low and `rd_data` is zero.
- R9: Dropping `core_en` flushes the queue with the same timing as R8. Headers that arrive while the core is disabled are not queued.
- R10: After `core_en` is high and `soft_rst` is low, the controller returns to RUN on the next edge. Headers are captured from the following cycle onward.
- R11: `fifo_empty` is high exactly when no entry is held. It is never high together with `fifo_full`.
- R12: When a push and a read strobe fall in the same cycle, the read returns the old head. The push is judged against the occupancy before the pop: it is stored when the queue was not full, and discarded (setting `ovf_flag`) when it was full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| core_en | input | 1 | Core enable; low flushes and holds the block idle |
| soft_rst | input | 1 | Soft reset request; high flushes the block |
| hdr_valid | input | 1 | Decoded short packet header is present this cycle |
| hdr_dtype | input | 6 | Header data type |
| hdr_vc | input | 2 | Header virtual channel |
| hdr_data | input | 16 | Header 16-bit payload |
| rd_stb | input | 1 | Read strobe: return and remove the head entry |
| rd_data | output | 32 | Last read word |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds 31 entries |
| ovf_flag | output | 1 | Sticky: a qualifying header was lost to a full queue |

## Verification
The bench builds the block with its default parameters: a depth of 31 and the qualifying window 0x08..0x0F. These values are small enough to fill the queue completely and then push past it. That exercises the PARTIAL->FULL and FULL->PARTIAL edges, the discard on overflow, and the full-queue case of a push and a pop in the same cycle, all within a short run. The window edges 0x07, 0x08, 0x0F and 0x10 are all driven, so both limits of the filter are tested.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    localparam int PAY_W = 16;
    localparam int VC_W  = 2;
    localparam int DT_W  = 6;
    localparam int ENT_W = PAY_W + VC_W + DT_W;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [VC_W-1:0]  vc;
        logic [DT_W-1:0]  dt;
    } gsp_entry_t;

    typedef enum logic {
        CS_FLUSH = 1'b0,
        CS_RUN   = 1'b1
    } ctrl_state_t;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
    import gsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_en,
    input  logic soft_rst,
    output logic flush,
    output logic run
);

    ctrl_state_t state_q, state_d;
    logic        hold_off;

    assign hold_off = !core_en || soft_rst;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_FLUSH: if (!hold_off) state_d = CS_RUN;
            CS_RUN:   if (hold_off)  state_d = CS_FLUSH;
            default:  state_d = CS_FLUSH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_FLUSH;
        else        state_q <= state_d;
    end

    always_comb begin
        flush = 1'b0;
        run   = 1'b0;
        unique case (state_q)
            CS_FLUSH: flush = 1'b1;
            CS_RUN:   run   = 1'b1;
            default:  flush = 1'b1;
        endcase
    end

endmodule

// File: rtl/gsp_filter.sv
module gsp_filter
    import gsp_pkg::*;
#(
    parameter logic [DT_W-1:0] GSP_LO = 6'h08,
    parameter logic [DT_W-1:0] GSP_HI = 6'h0F
) (
    input  logic             hdr_valid,
    input  logic [DT_W-1:0]  hdr_dtype,
    output logic             keep
);

    always_comb begin
        keep = hdr_valid && (hdr_dtype >= GSP_LO) && (hdr_dtype <= GSP_HI);
    end

endmodule

// File: rtl/gsp_fifo.sv
module gsp_fifo
    import gsp_pkg::*;
#(
    parameter int DEPTH = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  gsp_entry_t wdata,
    input  logic       pop,
    output gsp_entry_t head,
    output logic       empty,
    output logic       full,
    output logic       dropped
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    gsp_entry_t     mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt_q, cnt_d;
    occ_state_t     occ_q, occ_d;
    logic           do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (occ_q != OCC_FULL);
    assign do_pop  = pop  && (occ_q != OCC_EMPTY);
    assign dropped = push && (occ_q == OCC_FULL);
    assign cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);

    always_comb begin
        occ_d = occ_q;
        if (clr) begin
            occ_d = OCC_EMPTY;
        end else begin
            unique case (occ_q)
                OCC_EMPTY:   if (do_push) occ_d = (cnt_d == CAP) ? OCC_FULL : OCC_PARTIAL;
                OCC_PARTIAL: begin
                    if (cnt_d == '0)       occ_d = OCC_EMPTY;
                    else if (cnt_d == CAP) occ_d = OCC_FULL;
                end
                OCC_FULL:    if (do_pop) occ_d = (cnt_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
                default:     occ_d = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (occ_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full = 1'b1;
            default:     empty = 1'b1;
        endcase
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/gsp_capture_top.sv
module gsp_capture_top
    import gsp_pkg::*;
#(
    parameter int               DEPTH  = 31,
    parameter logic [DT_W-1:0]  GSP_LO = 6'h08,
    parameter logic [DT_W-1:0]  GSP_HI = 6'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic              soft_rst,
    input  logic              hdr_valid,
    input  logic [DT_W-1:0]   hdr_dtype,
    input  logic [VC_W-1:0]   hdr_vc,
    input  logic [PAY_W-1:0]  hdr_data,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              ovf_flag
);

    localparam int PAD_W = WORD_W - ENT_W;

    logic       flush, run, keep, push, pop, dropped;
    gsp_entry_t wr_ent, head;
    logic [WORD_W-1:0] rd_q;
    logic              ovf_q;

    gsp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_en  (core_en),
        .soft_rst (soft_rst),
        .flush    (flush),
        .run      (run)
    );

    gsp_filter #(.GSP_LO(GSP_LO), .GSP_HI(GSP_HI)) u_filt (
        .hdr_valid (hdr_valid),
        .hdr_dtype (hdr_dtype),
        .keep      (keep)
    );

    assign wr_ent = '{pay: hdr_data, vc: hdr_vc, dt: hdr_dtype};
    assign push   = run && keep;
    assign pop    = run && rd_stb;

    gsp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .push    (push),
        .wdata   (wr_ent),
        .pop     (pop),
        .head    (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .dropped (dropped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (rd_stb) rd_q <= fifo_empty ? '0 : {{PAD_W{1'b0}}, head};
            if (dropped) ovf_q <= 1'b1;
        end
    end

    assign rd_data  = rd_q;
    assign ovf_flag = ovf_q;

endmodule

// File: rtl/gsp_capture_chk.sv
module gsp_capture_chk
    import gsp_pkg::*;
#(
    parameter logic [DT_W-1:0] GSP_LO = 6'h08,
    parameter logic [DT_W-1:0] GSP_HI = 6'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_en,
    input logic              soft_rst,
    input logic              hdr_valid,
    input logic [DT_W-1:0]   hdr_dtype,
    input logic              rd_stb,
    input logic [WORD_W-1:0] rd_data,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              ovf_flag
);

    logic [1:0] seen;
    logic       settled, in_win, live;

    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assign settled = (seen >= 2'd2);
    assign in_win  = (hdr_dtype >= GSP_LO) && (hdr_dtype <= GSP_HI);
    assign live    = core_en && !soft_rst;

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:24] == 8'd0);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && fifo_empty) |=> (rd_data == '0));

    p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(fifo_full && hdr_valid));

    p_soft_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ##1 (fifo_empty && !ovf_flag && rd_data == '0));

    p_disable_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> ##1 (fifo_empty && !fifo_full));

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && live && $past(live) && fifo_empty && hdr_valid && in_win && !rd_stb)
        |=> !fifo_empty);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && live && $past(live) && !hdr_valid && !rd_stb)
        |=> ($stable(fifo_empty) && $stable(fifo_full) && $stable(rd_data)));

endmodule

bind gsp_capture_top gsp_capture_chk #(.GSP_LO(GSP_LO), .GSP_HI(GSP_HI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_en    (core_en),
    .soft_rst   (soft_rst),
    .hdr_valid  (hdr_valid),
    .hdr_dtype  (hdr_dtype),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .ovf_flag   (ovf_flag)
);

// File: tb/sim_gsp_capture_top.sv
`timescale 1ns/1ps
module sim_gsp_capture_top;

    localparam int DEPTH = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_en = 1'b0;
    logic        soft_rst = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [5:0]  hdr_dtype = '0;
    logic [1:0]  hdr_vc = '0;
    logic [15:0] hdr_data = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic        fifo_empty, fifo_full, ovf_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    bit          model_live = 0;
    bit          exp_ovf = 0;

    always #2.5 clk = ~clk;

    gsp_capture_top u0 (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .soft_rst(soft_rst),
        .hdr_valid(hdr_valid), .hdr_dtype(hdr_dtype), .hdr_vc(hdr_vc),
        .hdr_data(hdr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit qual(input logic [5:0] dt);
        return (dt >= 6'h08) && (dt <= 6'h0F);
    endfunction

    // driver: present one header (optionally with a read strobe) for one cycle
    task automatic drive(input logic [5:0] dt, input logic [1:0] vc,
                         input logic [15:0] d, input bit with_rd, input bit with_hdr);
        logic [31:0] exp_rd;
        bit          had_room;
        had_room = exp_q.size() < DEPTH;
        exp_rd = 32'd0;
        if (with_rd && model_live && exp_q.size() != 0) exp_rd = exp_q.pop_front();
        if (with_hdr && model_live && qual(dt)) begin
            if (had_room) exp_q.push_back({8'd0, d, vc, dt});
            else          exp_ovf = 1;
        end
        hdr_valid = with_hdr; hdr_dtype = dt; hdr_vc = vc; hdr_data = d;
        rd_stb = with_rd;
        @(negedge clk);
        hdr_valid = 0; rd_stb = 0;
        if (with_rd) chk(with_hdr ? "R12 read word" : "R5 read word", rd_data, exp_rd);
    endtask

    task automatic send(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] d);
        drive(dt, vc, d, 0, 1);
    endtask

    task automatic rd();
        drive(6'h0, 2'd0, 16'h0, 1, 0);
    endtask

    task automatic chk_flags(input string req);
        chk({req, " empty"}, {31'd0, fifo_empty}, {31'd0, exp_q.size() == 0});
        chk({req, " full"},  {31'd0, fifo_full},  {31'd0, exp_q.size() == DEPTH});
        chk({req, " ovf"},   {31'd0, ovf_flag},   {31'd0, exp_ovf});
    endtask

    task automatic flush_model();
        exp_q.delete();
        exp_ovf = 0;
        model_live = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 rd_data", rd_data, 32'd0);
        chk_flags("R7");
        rst_n = 1; core_en = 1;
        @(negedge clk); @(negedge clk);
        model_live = 1;

        // R6: empty read
        rd();
        chk_flags("R6");

        // R1, R2: filter window edges and layout
        send(6'h08, 2'd1, 16'hA55A);
        send(6'h00, 2'd0, 16'h1111);
        send(6'h07, 2'd2, 16'h2222);
        send(6'h0F, 2'd3, 16'hBEEF);
        send(6'h10, 2'd1, 16'h3333);
        send(6'h12, 2'd0, 16'h4444);
        send(6'h0C, 2'd2, 16'h0001);
        chk_flags("R1");
        chk("R1 count", exp_q.size(), 3);
        rd(); rd(); rd();
        chk_flags("R11");
        rd();

        // R3, R4: fill and overflow
        for (int i = 0; i < DEPTH; i++) send(6'h08 + 6'(i % 8), 2'(i), 16'(i * 16'h0101 + 16'h10));
        chk_flags("R3");
        send(6'h09, 2'd1, 16'hDEAD);
        send(6'h0A, 2'd2, 16'hCAFE);
        chk_flags("R4");
        for (int i = 0; i < DEPTH; i++) rd();
        chk_flags("R4 drained");
        rd();
        chk_flags("R6 after drain");

        // R12: push with pop, not full
        send(6'h0D, 2'd0, 16'h1234);
        drive(6'h0E, 2'd1, 16'h5678, 1, 1);
        chk_flags("R12 partial");
        rd();
        // R12: push with pop, full
        for (int i = 0; i < DEPTH; i++) send(6'h0B, 2'd3, 16'(16'h4000 + i));
        drive(6'h0B, 2'd0, 16'hFFFF, 1, 1);
        chk_flags("R12 full");
        rd();
        chk_flags("R12 after");

        // R8: soft reset flush
        soft_rst = 1; flush_model();
        @(negedge clk); @(negedge clk);
        chk("R8 rd_data", rd_data, 32'd0);
        chk_flags("R8");
        soft_rst = 0;
        @(negedge clk);
        model_live = 1;
        // R10: capture resumes
        send(6'h08, 2'd2, 16'h7777);
        chk_flags("R10");
        rd();

        // R9: core disable
        send(6'h09, 2'd1, 16'h0909);
        core_en = 0; flush_model();
        @(negedge clk);
        send(6'h0A, 2'd1, 16'h0A0A);
        send(6'h0B, 2'd1, 16'h0B0B);
        chk_flags("R9");
        core_en = 1;
        @(negedge clk);
        model_live = 1;
        chk_flags("R9 re-enabled");
        rd();

        // R7: hardware reset with content
        send(6'h0C, 2'd0, 16'hC0C0);
        send(6'h0D, 2'd0, 16'hD0D0);
        rd();
        rst_n = 0; flush_model();
        @(negedge clk);
        chk("R7 rd_data mid", rd_data, 32'd0);
        chk_flags("R7 mid");
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        model_live = 1;
        send(6'h0F, 2'd1, 16'h5A5A);
        rd();
        chk_flags("R5 final");

        finish_run();
    end

endmodule